// File: doc/BRIEF.md
# Calendar Time Register Keeper

This block keeps wall-clock time and a calendar date as counters behind a small memory-mapped register file. One packed word holds hours, minutes and seconds; a second packed word holds the day, the month, a year offset and a leap-year flag that software sets. A one-cycle pulse on the tick input advances the time by one second. Carries ripple from seconds through minutes and hours into the day, and from there into the month and the year.

Software loads a new time or date by writing the packed word. The block does not apply the value at once. It holds the value in a shadow register and raises a busy flag in the control word for a fixed, parameterised number of cycles. At the end of that window the shadow value replaces the counters. Until then, reads return the running counters. Software writes the time first, waits for its busy flag to drop, and then writes the date in the same way. The two commit paths are independent, so the second write is also accepted while the first one is still pending.

Top module: `cal_regkeeper`

## Requirements
- R1: After a synchronous active-low reset, the time word reads 0, the date word reads day 1, month 1, year 0 with the leap flag clear, and both busy flags read 0.
- R2: The word at offset 0x0 is the control word, 0x4 is the date word and 0x8 is the time word. Any other offset reads 0. Writes to the control word change nothing.
- R3: Time word layout: seconds in bits [5:0], minutes in bits [13:8], hours in bits [20:16]. All other bits read 0.
- R4: Date word layout: day in bits [4:0], month (1 to 12) in bits [11:8], year offset in bits starting at 16 and YEAR_W bits wide, leap flag at bit 16+YEAR_W (bit 24 when YEAR_W is 8). All other bits read 0.
- R5: An accepted write to the time word sets control bit 8 for exactly COMMIT_LAT cycles. In the cycle after that window, bit 8 reads 0 and the time word holds the written value.
- R6: An accepted write to the date word sets control bit 7 with the same timing, and then the date word holds the written value, including the leap flag.
- R7: While a commit is pending, the register reads return the counters, and those counters keep advancing on ticks. A tick that lands on the commit cycle is overridden by the committed value.
- R8: A write to the time or date word that arrives while that word's own busy flag is set is ignored.
- R9: On a tick, seconds roll from 59 to 0 and carry into minutes, minutes roll from 59 to 0 and carry into hours, and hours roll from 23 to 0 and carry into the day.
- R10: The day rolls to 1 after the last day of the month. Months 4, 6, 9 and 11 have 30 days. Month 2 has 28 days, or 29 when the leap flag is set. All other months have 31 days.
- R11: Month 12 rolls to 1 and increments the year field, which wraps to 0 from its maximum value. The leap flag does not change on rollover.
- R12: A date write accepted while the time commit is still pending commits independently, and both words end up holding their written values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse marking one elapsed second |
| bus_we_i | input | 1 | Write strobe, sampled on the clock edge |
| bus_addr_i | input | ADDR_W | Byte offset of the accessed word |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |

## Verification
The hardest situation to reach from the ports is the overlap of activity inside a commit window. This covers a tick that advances the old counters while a new value waits in the shadow register, a second write to the same word that must be dropped, and a date write accepted while the time commit is still open. The stimulus reaches these cases with directed sequences that are timed cycle by cycle from the write strobe. The rollover chain is driven by directed boundary dates (year end, February with and without the leap flag, 30-day months, year-field wrap), mixed with seeded random time/date loads, many of them biased to the last second of a month, followed by short random tick bursts.

// File: rtl/cal_pkg.sv
// Package: shared field widths, register offsets and the month length rule
// for the calendar register keeper.
// Assumes: months are one-based (1..12); out-of-range months fall back to 31 days.
package cal_pkg;
    localparam int unsigned SEC_W = 6;
    localparam int unsigned MIN_W = 6;
    localparam int unsigned HR_W  = 5;
    localparam int unsigned DAY_W = 5;
    localparam int unsigned MON_W = 4;
    localparam int unsigned HMS_W = SEC_W + MIN_W + HR_W;

    // Bit positions the driver side depends on
    localparam int unsigned TBUSY_BIT = 8;
    localparam int unsigned DBUSY_BIT = 7;
    localparam int unsigned MIN_POS   = 8;
    localparam int unsigned HR_POS    = 16;
    localparam int unsigned MON_POS   = 8;
    localparam int unsigned YEAR_POS  = 16;

    typedef struct packed {
        logic [HR_W-1:0]  hr;
        logic [MIN_W-1:0] mn;
        logic [SEC_W-1:0] sc;
    } hms_t;

    // Number of days in a month, given the stored leap flag
    function automatic logic [DAY_W-1:0] month_len(input logic [MON_W-1:0] mon,
                                                   input logic leap);
        logic [DAY_W-1:0] len;
        case (mon)
            4'd2:                   len = leap ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11: len = 5'd30;
            default:                len = 5'd31;
        endcase
        return len;
    endfunction
endpackage

// File: rtl/cal_commit.sv
// Module: cal_commit
// Holds a software-written value in a shadow register and releases it to the
// counters after a fixed number of cycles; busy_o stays high for that window.
// Assumes: LAT >= 1; a start while busy is dropped without touching the shadow.
module cal_commit #(
    parameter int unsigned W   = 17,
    parameter int unsigned LAT = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] data_i,
    output logic         busy_o,
    output logic         load_o,
    output logic [W-1:0] data_o
);
    localparam int unsigned CNT_W = $clog2(LAT + 1);
    localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(LAT);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [W-1:0]     shadow_q;

    // Countdown and shadow capture; a start is accepted only when idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            shadow_q <= '0;
        end else if (start_i && (cnt_q == '0)) begin
            cnt_q    <= CNT_INIT;
            shadow_q <= data_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_LAST;
        end
    end

    assign busy_o = (cnt_q != '0);
    assign load_o = (cnt_q == CNT_LAST);
    assign data_o = shadow_q;

    // R8: a start during a pending commit leaves the shadow untouched
    p_drop_when_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && busy_o) |=> $stable(shadow_q));

    // R5: the load cycle ends the busy window
    p_busy_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> !busy_o);

    // R5: busy only rises in response to a start
    p_busy_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));
endmodule

// File: rtl/cal_time_cnt.sv
// Module: cal_time_cnt
// Hours/minutes/seconds counter. It advances on tick_i and raises day_carry_o
// when the tick wraps 23:59:59. A load takes priority over a tick in the same cycle.
// Assumes: tick_i is a single-cycle pulse synchronous to clk.
module cal_time_cnt
    import cal_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic load_i,
    input  hms_t load_val_i,
    output hms_t hms_o,
    output logic day_carry_o
);
    localparam logic [SEC_W-1:0] SEC_MAX = 6'd59;
    localparam logic [MIN_W-1:0] MIN_MAX = 6'd59;
    localparam logic [HR_W-1:0]  HR_MAX  = 5'd23;

    hms_t cur_q;
    logic sec_wrap, min_wrap, hr_wrap;

    // Wrap detection for each field
    always_comb begin
        sec_wrap = (cur_q.sc >= SEC_MAX);
        min_wrap = (cur_q.mn >= MIN_MAX);
        hr_wrap  = (cur_q.hr >= HR_MAX);
    end

    // Counter update: load first, then the tick with a ripple carry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else if (load_i) begin
            cur_q <= load_val_i;
        end else if (tick_i) begin
            if (sec_wrap) begin
                cur_q.sc <= '0;
                if (min_wrap) begin
                    cur_q.mn <= '0;
                    cur_q.hr <= hr_wrap ? '0 : cur_q.hr + 5'd1;
                end else begin
                    cur_q.mn <= cur_q.mn + 6'd1;
                end
            end else begin
                cur_q.sc <= cur_q.sc + 6'd1;
            end
        end
    end

    assign hms_o       = cur_q;
    assign day_carry_o = tick_i && !load_i && sec_wrap && min_wrap && hr_wrap;

    // R9: a tick at second 59 wraps seconds to zero
    p_sec_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_i && cur_q.sc == SEC_MAX) |=> (cur_q.sc == '0));

    // R7: without a tick or a load the time holds
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !load_i) |=> $stable(cur_q));

    // R9: the day carry only comes from the last second of the day
    p_carry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        day_carry_o |=> (cur_q == '0));
endmodule

// File: rtl/cal_date_cnt.sv
// Module: cal_date_cnt
// Day/month/year counter with a leap flag written by software. It advances one
// day on adv_i. A load takes priority over the advance in the same cycle.
// Assumes: the leap flag is owned by software and is never changed by rollover.
module cal_date_cnt
    import cal_pkg::*;
#(
    parameter int unsigned YEAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_i,
    input  logic              load_i,
    input  logic [DAY_W-1:0]  load_day_i,
    input  logic [MON_W-1:0]  load_mon_i,
    input  logic [YEAR_W-1:0] load_year_i,
    input  logic              load_leap_i,
    output logic [DAY_W-1:0]  day_o,
    output logic [MON_W-1:0]  mon_o,
    output logic [YEAR_W-1:0] year_o,
    output logic              leap_o
);
    localparam logic [MON_W-1:0]  MON_LAST = 4'd12;
    localparam logic [YEAR_W-1:0] YEAR_ONE = YEAR_W'(1);

    logic [DAY_W-1:0]  day_q;
    logic [MON_W-1:0]  mon_q;
    logic [YEAR_W-1:0] year_q;
    logic              leap_q;
    logic              month_end;

    // Last day of the current month, given the stored leap flag
    assign month_end = (day_q >= month_len(mon_q, leap_q));

    // Calendar update: load first, then a one-day advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            day_q  <= 5'd1;
            mon_q  <= 4'd1;
            year_q <= '0;
            leap_q <= 1'b0;
        end else if (load_i) begin
            day_q  <= load_day_i;
            mon_q  <= load_mon_i;
            year_q <= load_year_i;
            leap_q <= load_leap_i;
        end else if (adv_i) begin
            if (month_end) begin
                day_q <= 5'd1;
                if (mon_q >= MON_LAST) begin
                    mon_q  <= 4'd1;
                    year_q <= year_q + YEAR_ONE;
                end else begin
                    mon_q <= mon_q + 4'd1;
                end
            end else begin
                day_q <= day_q + 5'd1;
            end
        end
    end

    assign day_o  = day_q;
    assign mon_o  = mon_q;
    assign year_o = year_q;
    assign leap_o = leap_q;

    // R11: the end of December rolls to January
    p_year_roll_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !load_i && month_end && mon_q == MON_LAST) |=> (mon_q == 4'd1));

    // R10: an advance at the end of the month restarts at day 1
    p_day_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !load_i && month_end) |=> (day_q == 5'd1));

    // R11: the leap flag only changes through a load
    p_leap_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(leap_q));
endmodule

// File: rtl/cal_regkeeper.sv
// Module: cal_regkeeper (top)
// Register file around the time and date counters: decodes writes into two
// commit units, exposes both busy flags and muxes the read data.
// Assumes: word offsets 0x0 control, 0x4 date, 0x8 time; reads are combinational.
module cal_regkeeper
    import cal_pkg::*;
#(
    parameter int unsigned YEAR_W     = 8,
    parameter int unsigned COMMIT_LAT = 4,
    parameter int unsigned ADDR_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o
);
    localparam int unsigned LEAP_POS = YEAR_POS + YEAR_W;
    localparam int unsigned DATE_W   = 1 + YEAR_W + MON_W + DAY_W;
    localparam logic [ADDR_W-1:0] CTRL_OFF = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] DATE_OFF = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] TIME_OFF = ADDR_W'(8);

    logic              time_wr, date_wr;
    hms_t              time_in, time_sh, hms_cur;
    logic [DATE_W-1:0] date_in, date_sh;
    logic              time_busy, time_load, date_busy, date_load, day_carry;
    logic [DAY_W-1:0]  day_cur;
    logic [MON_W-1:0]  mon_cur;
    logic [YEAR_W-1:0] year_cur;
    logic              leap_cur;

    // Write decode and field extraction from the packed bus words
    always_comb begin
        time_wr    = bus_we_i && (bus_addr_i == TIME_OFF);
        date_wr    = bus_we_i && (bus_addr_i == DATE_OFF);
        time_in.sc = bus_wdata_i[SEC_W-1:0];
        time_in.mn = bus_wdata_i[MIN_POS +: MIN_W];
        time_in.hr = bus_wdata_i[HR_POS +: HR_W];
        date_in    = {bus_wdata_i[LEAP_POS], bus_wdata_i[YEAR_POS +: YEAR_W],
                      bus_wdata_i[MON_POS +: MON_W], bus_wdata_i[DAY_W-1:0]};
    end

    cal_commit #(.W(HMS_W), .LAT(COMMIT_LAT)) time_commit_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (time_wr),
        .data_i  (time_in),
        .busy_o  (time_busy),
        .load_o  (time_load),
        .data_o  (time_sh)
    );

    cal_commit #(.W(DATE_W), .LAT(COMMIT_LAT)) date_commit_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (date_wr),
        .data_i  (date_in),
        .busy_o  (date_busy),
        .load_o  (date_load),
        .data_o  (date_sh)
    );

    cal_time_cnt time_cnt_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .load_i      (time_load),
        .load_val_i  (time_sh),
        .hms_o       (hms_cur),
        .day_carry_o (day_carry)
    );

    cal_date_cnt #(.YEAR_W(YEAR_W)) date_cnt_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .adv_i       (day_carry),
        .load_i      (date_load),
        .load_day_i  (date_sh[DAY_W-1:0]),
        .load_mon_i  (date_sh[DAY_W +: MON_W]),
        .load_year_i (date_sh[DAY_W+MON_W +: YEAR_W]),
        .load_leap_i (date_sh[DATE_W-1]),
        .day_o       (day_cur),
        .mon_o       (mon_cur),
        .year_o      (year_cur),
        .leap_o      (leap_cur)
    );

    // Read mux over the three words; unmapped offsets read zero
    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            CTRL_OFF: begin
                bus_rdata_o[TBUSY_BIT] = time_busy;
                bus_rdata_o[DBUSY_BIT] = date_busy;
            end
            DATE_OFF: begin
                bus_rdata_o[DAY_W-1:0]           = day_cur;
                bus_rdata_o[MON_POS +: MON_W]    = mon_cur;
                bus_rdata_o[YEAR_POS +: YEAR_W]  = year_cur;
                bus_rdata_o[LEAP_POS]            = leap_cur;
            end
            TIME_OFF: begin
                bus_rdata_o[SEC_W-1:0]       = hms_cur.sc;
                bus_rdata_o[MIN_POS +: MIN_W] = hms_cur.mn;
                bus_rdata_o[HR_POS +: HR_W]   = hms_cur.hr;
            end
            default: ;
        endcase
    end

    // R12: a time commit never disturbs a pending date commit
    p_indep_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (time_load && date_busy && !date_load) |=> date_busy);

    // R6: a date load is followed by the shadow value on the counters
    p_date_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        date_load |=> (day_cur == $past(date_sh[DAY_W-1:0])));
endmodule

// File: tb/cal_regkeeper_tb_top.sv
`timescale 1ns/1ps
module cal_regkeeper_tb_top;
    localparam int unsigned YW  = 8;
    localparam int unsigned LAT = 4;
    localparam int unsigned LP  = 16 + YW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        we = 1'b0;
    logic [3:0]  addr = 4'h0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // expected model
    int m_sc, m_mn, m_hr, m_day, m_mon, m_yr, m_leap;

    always #4 clk = ~clk;

    cal_regkeeper #(.YEAR_W(YW), .COMMIT_LAT(LAT), .ADDR_W(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .bus_we_i(we),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata)
    );

    function automatic logic [31:0] tword(int h, int m, int s);
        return (32'(h) << 16) | (32'(m) << 8) | 32'(s);
    endfunction

    function automatic logic [31:0] dword(int lp, int y, int mo, int d);
        return (32'(lp) << LP) | (32'(y) << 16) | (32'(mo) << 8) | 32'(d);
    endfunction

    function automatic int days_of(int mo, int lp);
        if (mo == 2) return (lp != 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic model_tick();
        m_sc++;
        if (m_sc == 60) begin
            m_sc = 0; m_mn++;
            if (m_mn == 60) begin
                m_mn = 0; m_hr++;
                if (m_hr == 24) begin
                    m_hr = 0; m_day++;
                    if (m_day > days_of(m_mon, m_leap)) begin
                        m_day = 1; m_mon++;
                        if (m_mon == 13) begin
                            m_mon = 1;
                            m_yr = (m_yr + 1) % (1 << YW);
                        end
                    end
                end
            end
        end
    endtask

    task automatic do_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        model_tick();
    endtask

    task automatic wait_idle();
        logic [31:0] c;
        for (int i = 0; i < 20; i++) begin
            rd(4'h0, c);
            if (c == 32'h0) break;
            @(negedge clk);
        end
    endtask

    task automatic set_all(int h, int m, int s, int lp, int y, int mo, int d);
        wr(4'h8, tword(h, m, s));
        wait_idle();
        wr(4'h4, dword(lp, y, mo, d));
        wait_idle();
        m_hr = h; m_mn = m; m_sc = s; m_leap = lp; m_yr = y; m_mon = mo; m_day = d;
    endtask

    task automatic cmp(input string req);
        logic [31:0] d;
        rd(4'h8, d);
        check({req, " time"}, d, tword(m_hr, m_mn, m_sc));
        rd(4'h4, d);
        check({req, " date"}, d, dword(m_leap, m_yr, m_mon, m_day));
    endtask

    initial begin
        #1_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(4'h0, d); check("R1 ctrl", d, 32'h0);
        rd(4'h8, d); check("R1 time", d, 32'h0);
        rd(4'h4, d); check("R1 date", d, dword(0, 0, 1, 1));
        m_hr = 0; m_mn = 0; m_sc = 0; m_leap = 0; m_yr = 0; m_mon = 1; m_day = 1;

        // R2 unmapped offset and ignored control write
        rd(4'hC, d); check("R2 unmapped", d, 32'h0);
        wr(4'h0, 32'hFFFF_FFFF);
        rd(4'h0, d); check("R2 ctrl write ignored", d, 32'h0);
        cmp("R2");

        // R5 and R3: busy window length and time layout (stray bits dropped)
        wr(4'h8, 32'hFFE0_C0C0 | tword(13, 45, 27));
        rd(4'h0, d); check("R5 busy set", d, 32'h100);
        repeat (3) @(negedge clk);
        rd(4'h0, d); check("R5 busy last cycle", d, 32'h100);
        rd(4'h8, d); check("R7 old time during commit", d, 32'h0);
        @(negedge clk);
        rd(4'h0, d); check("R5 busy cleared", d, 32'h0);
        rd(4'h8, d); check("R3 time layout", d, tword(13, 45, 27));
        m_hr = 13; m_mn = 45; m_sc = 27;

        // R6 and R4: date layout including the leap bit
        wr(4'h4, dword(1, 200, 7, 19));
        rd(4'h0, d); check("R6 busy set", d, 32'h80);
        repeat (3) @(negedge clk);
        rd(4'h0, d); check("R6 busy last cycle", d, 32'h80);
        @(negedge clk);
        rd(4'h0, d); check("R6 busy cleared", d, 32'h0);
        rd(4'h4, d); check("R4 date layout", d, dword(1, 200, 7, 19));
        m_leap = 1; m_yr = 200; m_mon = 7; m_day = 19;

        // R7: a tick during a pending commit moves the old time, then the load wins
        wr(4'h8, tword(5, 6, 7));
        do_tick();
        rd(4'h8, d); check("R7 old time advances", d, tword(13, 45, 28));
        wait_idle();
        m_hr = 5; m_mn = 6; m_sc = 7;
        cmp("R7 after commit");

        // R8: a second time write while busy is dropped
        wr(4'h8, tword(10, 20, 30));
        wr(4'h8, tword(11, 22, 33));
        wait_idle();
        rd(4'h8, d); check("R8 busy write ignored", d, tword(10, 20, 30));
        m_hr = 10; m_mn = 20; m_sc = 30;

        // R12: a date write while the time commit is pending
        wr(4'h8, tword(1, 2, 3));
        wr(4'h4, dword(0, 9, 3, 4));
        rd(4'h0, d); check("R12 both busy", d, 32'h180);
        wait_idle();
        m_hr = 1; m_mn = 2; m_sc = 3; m_leap = 0; m_yr = 9; m_mon = 3; m_day = 4;
        cmp("R12");

        // R9 carry chain and R11 year end
        set_all(23, 59, 59, 0, 17, 12, 31);
        do_tick(); cmp("R11 year end");
        set_all(8, 59, 59, 0, 3, 5, 10);
        do_tick(); cmp("R9 hour carry");
        // R10 February with and without the leap flag, and a 30-day month
        set_all(23, 59, 59, 0, 3, 2, 28);
        do_tick(); cmp("R10 feb no leap");
        set_all(23, 59, 59, 1, 4, 2, 28);
        do_tick(); cmp("R10 feb leap 29");
        do_tick(); cmp("R10 feb leap holds");
        set_all(23, 59, 59, 1, 4, 2, 29);
        do_tick(); cmp("R10 feb leap end");
        set_all(23, 59, 59, 0, 4, 4, 30);
        do_tick(); cmp("R10 30-day month");
        // R11 year field wrap
        set_all(23, 59, 59, 1, (1 << YW) - 1, 12, 31);
        do_tick(); cmp("R11 year wrap");

        // random loads and tick bursts, covering R9, R10 and R11
        for (int it = 0; it < 40; it++) begin
            int h, m, s, lp, y, mo, dd, n;
            lp = int'($urandom_range(0, 1));
            y  = int'($urandom_range(0, (1 << YW) - 1));
            mo = int'($urandom_range(1, 12));
            if ($urandom_range(0, 1) == 1) begin
                h = 23; m = 59; s = int'($urandom_range(57, 59));
                dd = days_of(mo, lp);
            end else begin
                h = int'($urandom_range(0, 23));
                m = int'($urandom_range(0, 59));
                s = int'($urandom_range(0, 59));
                dd = int'($urandom_range(1, days_of(mo, lp)));
            end
            set_all(h, m, s, lp, y, mo, dd);
            n = int'($urandom_range(1, 6));
            for (int k = 0; k < n; k++) do_tick();
            cmp("R9 R10 R11 random");
        end

        summary();
    end
endmodule